// File: doc/BRIEF.md
# Per-Processor Pending Interrupt Bank

This block keeps one 32-bit pending-interrupt word for each of up to sixteen processors. Each word is reached through its own 4 KB window: address bits [15:12] pick the processor and address bits [3:2] pick the word offset inside the window. Software uses a simple single-cycle register port to read a word, to raise soft-interrupt bits and to drop bits again. Soft-interrupt writes only reach the upper fifteen bits, [31:17].

The system interrupt router has a second, hardware port. Through it, the router raises or lowers a single priority-level bit (levels 1 to 15) in the word of a chosen processor. All pending words are also presented side by side on a flat output vector, so that each processor can resolve its own priority.

Top module: `cpu_pend_bank`

## Requirements
- R1: After reset every pending word is zero and the read data output is zero.
- R2: A read request (`req_sel`=1, `req_wr`=0) with address bits [3:2]=0 returns, on `rsp_rdata` one cycle later, the word of the processor named by address bits [15:12]. `rsp_rdata` holds its value in cycles without a read request.
- R3: A read request with address bits [3:2] equal to 1, 2 or 3 returns zero one cycle later.
- R4: A write at offset 2 ORs (write data AND 0xFFFE0000) into the addressed word.
- R5: A write at offset 1 clears, in the addressed word, every bit that is set in (write data AND 0xFFFE0000).
- R6: A write at offset 1 whose data has bit 14 set also clears bit 31 of the addressed word.
- R7: Writes at offset 0 and at offset 3 change no word.
- R8: A write changes only the word of the processor named by address bits [15:12]. Address bits [11:4] and [1:0] have no effect.
- R9: A hardware request (`hw_valid`=1, `hw_set`=1) sets bit `hw_level` of the word of processor `hw_cpu`. The change is visible on the next cycle.
- R10: A hardware request with `hw_set`=0 clears bit `hw_level` of the word of processor `hw_cpu`.
- R11: A hardware request with `hw_level`=0 changes no word.
- R12: When a bus write and a hardware request reach the same word in the same cycle, both take effect. The hardware change is applied after the bus change.
- R13: Bits 0 and 16 of every word stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_sel | input | 1 | Register access request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address: [15:12] processor, [3:2] offset |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid one cycle after a read request |
| hw_valid | input | 1 | Hardware level update strobe |
| hw_set | input | 1 | 1 = set level bit, 0 = clear it |
| hw_level | input | 4 | Level number, 1 to 15 |
| hw_cpu | input | 4 | Target processor index |
| pend_flat | output | 512 | All pending words; processor i occupies bits [32i+31:32i] |

## Verification
The bench aims at the masking corners. Writing all ones at offset 2 must leave bits 0 to 16 clear; a design with a wrong mask would leak low bits or bit 16. A clear write carrying only bit 14 must drop bit 31 and nothing else; a design that missed the pairing would keep bit 31. Writes at offsets 0 and 3, and writes with junk in address bits [11:4], must leave all sixteen words untouched; a loose decoder would corrupt a neighbour. Hardware requests at level 0, and bus writes that coincide with hardware updates on the same word, are also checked: a design with a bad priority merge would lose one of the two updates, and a design with a missing level guard would set bit 0.

// File: rtl/cpb_pkg.sv
package cpb_pkg;
  typedef enum logic [1:0] {
    OFF_STATUS = 2'd0,
    OFF_DROP   = 2'd1,
    OFF_RAISE  = 2'd2,
    OFF_SPARE  = 2'd3
  } cpb_off_e;

  localparam logic [31:0] SOFT_FIELD = 32'hFFFE_0000;
  localparam int          PAIR_SRC   = 14;
  localparam int          PAIR_DST   = 31;
  localparam int          GAP_BIT    = 16;
endpackage

// File: rtl/cpb_decode.sv
module cpb_decode #(
  parameter int NUM_CPU = 16,
  parameter int ADDR_W  = 16,
  parameter int CPU_LSB = 12,
  parameter int OFF_LSB = 2,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               req_sel,
  input  logic               req_wr,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic [NUM_CPU-1:0] wr_hit,
  output logic               wr_drop,
  output logic               wr_raise,
  output logic               rd_en,
  output logic               rd_live,
  output logic [CPU_W-1:0]   cpu_idx
);
  import cpb_pkg::*;

  cpb_off_e off;

  always_comb begin
    cpu_idx  = req_addr[CPU_LSB +: CPU_W];
    off      = cpb_off_e'(req_addr[OFF_LSB +: 2]);
    wr_drop  = (off == OFF_DROP);
    wr_raise = (off == OFF_RAISE);
    rd_en    = req_sel && !req_wr;
    rd_live  = (off == OFF_STATUS);
  end

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_hit
    assign wr_hit[g] = req_sel && req_wr && (cpu_idx == CPU_W'(g));
  end
endmodule

// File: rtl/cpb_pend_reg.sv
module cpb_pend_reg #(
  parameter int DATA_W = 32,
  parameter int LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_hit,
  input  logic              bus_drop,
  input  logic              bus_raise,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hw_hit,
  input  logic              hw_set,
  input  logic [LVL_W-1:0]  hw_level,
  output logic [DATA_W-1:0] q
);
  import cpb_pkg::*;

  logic [DATA_W-1:0] soft_bits;
  logic [DATA_W-1:0] drop_bits;
  logic [DATA_W-1:0] lvl_bit;
  logic [DATA_W-1:0] nxt;
  logic              en;

  always_comb begin
    soft_bits = wdata & SOFT_FIELD;
    drop_bits = soft_bits;
    if (wdata[PAIR_SRC]) drop_bits[PAIR_DST] = 1'b1;
    lvl_bit = DATA_W'(1) << hw_level;
    nxt = q;
    if (bus_hit && bus_drop)  nxt = nxt & ~drop_bits;
    if (bus_hit && bus_raise) nxt = nxt | soft_bits;
    if (hw_hit) nxt = hw_set ? (nxt | lvl_bit) : (nxt & ~lvl_bit);
    en = (bus_hit && (bus_drop || bus_raise)) || hw_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= nxt;
  end

  // R9
  hw_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_hit && hw_set) |=> q[$past(hw_level)]);
  // R10
  hw_clr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_hit && !hw_set) |=> !q[$past(hw_level)]);
  // R13
  gap_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q[0] && !q[GAP_BIT]);
  // R5
  drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hit && bus_drop && !hw_hit) |=> ((q & $past(wdata & SOFT_FIELD)) == '0));
endmodule

// File: rtl/cpb_rd_port.sv
module cpb_rd_port #(
  parameter int NUM_CPU = 16,
  parameter int DATA_W  = 32,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic                      rd_live,
  input  logic [CPU_W-1:0]          rd_cpu,
  input  logic [NUM_CPU*DATA_W-1:0] pend_flat,
  output logic [DATA_W-1:0]         rdata
);
  logic [DATA_W-1:0] pick;
  logic [DATA_W-1:0] rdata_nxt;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_CPU; i++) begin
      if (rd_cpu == CPU_W'(i)) pick = pend_flat[i*DATA_W +: DATA_W];
    end
    rdata_nxt = rd_live ? pick : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rdata_nxt;
  end
endmodule

// File: rtl/cpu_pend_bank.sv
module cpu_pend_bank #(
  parameter int NUM_CPU = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 16,
  parameter int LVL_W   = 4,
  parameter int CPU_LSB = 12,
  parameter int OFF_LSB = 2,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_sel,
  input  logic                      req_wr,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic [DATA_W-1:0]         rsp_rdata,
  input  logic                      hw_valid,
  input  logic                      hw_set,
  input  logic [LVL_W-1:0]          hw_level,
  input  logic [CPU_W-1:0]          hw_cpu,
  output logic [NUM_CPU*DATA_W-1:0] pend_flat
);
  logic [NUM_CPU-1:0] wr_hit;
  logic               wr_drop;
  logic               wr_raise;
  logic               rd_en;
  logic               rd_live;
  logic [CPU_W-1:0]   cpu_idx;

  cpb_decode #(
    .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .CPU_LSB(CPU_LSB), .OFF_LSB(OFF_LSB)
  ) decode_i (
    .req_sel(req_sel), .req_wr(req_wr), .req_addr(req_addr),
    .wr_hit(wr_hit), .wr_drop(wr_drop), .wr_raise(wr_raise),
    .rd_en(rd_en), .rd_live(rd_live), .cpu_idx(cpu_idx)
  );

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
    logic hw_hit;
    assign hw_hit = hw_valid && (hw_cpu == CPU_W'(g)) && (hw_level != '0);

    cpb_pend_reg #(.DATA_W(DATA_W), .LVL_W(LVL_W)) reg_i (
      .clk(clk), .rst_n(rst_n),
      .bus_hit(wr_hit[g]), .bus_drop(wr_drop), .bus_raise(wr_raise),
      .wdata(req_wdata),
      .hw_hit(hw_hit), .hw_set(hw_set), .hw_level(hw_level),
      .q(pend_flat[g*DATA_W +: DATA_W])
    );
  end

  cpb_rd_port #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) rd_i (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_live(rd_live), .rd_cpu(cpu_idx),
    .pend_flat(pend_flat), .rdata(rsp_rdata)
  );

  // R3
  spare_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sel && !req_wr && (req_addr[OFF_LSB +: 2] != 2'd0)) |=> (rsp_rdata == '0));
  // R7
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_sel && req_wr) && !hw_valid) |=> $stable(pend_flat));
  // R11
  lvl_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_sel && req_wr) && hw_valid && (hw_level == '0)) |=> $stable(pend_flat));
endmodule

// File: tb/cpu_pend_bank_tb.sv
module cpu_pend_bank_tb_top;
  localparam int NC = 16;
  localparam int DW = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_sel = 1'b0;
  logic           req_wr = 1'b0;
  logic [15:0]    req_addr = '0;
  logic [31:0]    req_wdata = '0;
  logic [31:0]    rsp_rdata;
  logic           hw_valid = 1'b0;
  logic           hw_set = 1'b0;
  logic [3:0]     hw_level = '0;
  logic [3:0]     hw_cpu = '0;
  logic [NC*DW-1:0] pend_flat;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [NC];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_seen;
  bit          done = 0;

  always #2.5 clk = ~clk;

  cpu_pend_bank dut_i (
    .clk(clk), .rst_n(rst_n), .req_sel(req_sel), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .hw_valid(hw_valid), .hw_set(hw_set), .hw_level(hw_level),
    .hw_cpu(hw_cpu), .pend_flat(pend_flat)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < NC; i++)
      chk(pend_flat[i*DW +: DW] === model[i], $sformatf("%s cpu%0d", tag, i),
          pend_flat[i*DW +: DW], model[i]);
  endtask

  function automatic void model_bus(input int cpu, input int off, input logic [31:0] d);
    logic [31:0] m;
    m = d & 32'hFFFE_0000;
    if (off == 1) begin
      if (d[14]) m[31] = 1'b1;
      model[cpu] &= ~m;
    end else if (off == 2) begin
      model[cpu] |= m;
    end
  endfunction

  function automatic void model_hw(input int cpu, input bit s, input int lvl);
    if (lvl != 0) begin
      if (s) model[cpu] |= (32'd1 << lvl);
      else   model[cpu] &= ~(32'd1 << lvl);
    end
  endfunction

  task automatic bus_wr(input int cpu, input int off, input logic [31:0] d, input logic [11:0] junk);
    @(negedge clk);
    req_sel = 1; req_wr = 1; req_wdata = d;
    req_addr = {cpu[3:0], junk[11:4], off[1:0], junk[1:0]};
    model_bus(cpu, off, d);
    @(negedge clk);
    req_sel = 0; req_wr = 0;
  endtask

  task automatic hw_req(input int cpu, input bit s, input int lvl);
    @(negedge clk);
    hw_valid = 1; hw_set = s; hw_level = lvl[3:0]; hw_cpu = cpu[3:0];
    model_hw(cpu, s, lvl);
    @(negedge clk);
    hw_valid = 0;
  endtask

  task automatic both(input int cpu, input int off, input logic [31:0] d, input bit s, input int lvl);
    @(negedge clk);
    req_sel = 1; req_wr = 1; req_wdata = d;
    req_addr = {cpu[3:0], 8'h00, off[1:0], 2'b00};
    hw_valid = 1; hw_set = s; hw_level = lvl[3:0]; hw_cpu = cpu[3:0];
    model_bus(cpu, off, d);
    model_hw(cpu, s, lvl);
    @(negedge clk);
    req_sel = 0; req_wr = 0; hw_valid = 0;
  endtask

  // driver: pushes expected read data into the scoreboard queue
  task automatic bus_rd(input int cpu, input int off, input string tag);
    @(negedge clk);
    req_sel = 1; req_wr = 0;
    req_addr = {cpu[3:0], 8'h5A, off[1:0], 2'b00};
    exp_q.push_back(off == 0 ? model[cpu] : 32'h0);
    tag_q.push_back(tag);
    @(negedge clk);
    req_sel = 0;
  endtask

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_seen <= 1'b0;
    else        rd_seen <= req_sel && !req_wr;
  end

  // monitor: pops one expected item per completed read
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rsp_rdata === e, t, rsp_rdata, e);
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %08h expected %08h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NC; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");
    chk(rsp_rdata === 32'h0, "R1 rdata reset", rsp_rdata, 32'h0);

    bus_wr(3, 2, 32'hFFFF_FFFF, 12'h000);
    check_all("R4 raise all ones / R13 gap bits");
    bus_rd(3, 0, "R2 read cpu3");
    bus_rd(3, 1, "R3 read off1");
    bus_rd(3, 2, "R3 read off2");
    bus_rd(3, 3, "R3 read off3");
    repeat (3) @(negedge clk);
    chk(rsp_rdata === 32'h0, "R2 rdata holds", rsp_rdata, 32'h0);

    bus_wr(3, 1, 32'h0000_4000, 12'h000);
    check_all("R6 bit14 drops bit31");
    bus_wr(3, 1, 32'h0006_0001, 12'h000);
    check_all("R5 drop bits 17,18");
    bus_rd(3, 0, "R2 read after drop");

    bus_wr(5, 0, 32'hFFFF_FFFF, 12'h000);
    bus_wr(5, 3, 32'hFFFF_FFFF, 12'h000);
    check_all("R7 offsets 0,3 ignored");

    bus_wr(15, 2, 32'h1234_5678, 12'hFF3);
    check_all("R8 junk address bits");
    bus_rd(15, 0, "R8 read cpu15");
    bus_wr(0, 2, 32'hA000_0000, 12'hAB1);
    check_all("R8 cpu0 only");

    hw_req(2, 1, 5);
    check_all("R9 hw set lvl5");
    hw_req(2, 1, 15);
    hw_req(9, 1, 1);
    check_all("R9 hw set lvl15, lvl1");
    hw_req(2, 0, 5);
    check_all("R10 hw clear lvl5");
    hw_req(4, 1, 0);
    hw_req(2, 0, 0);
    check_all("R11 level 0 ignored");
    bus_rd(2, 0, "R9 read cpu2");

    both(2, 1, 32'h8000_4000, 1, 3);
    check_all("R12 drop with hw set");
    both(2, 2, 32'hC000_0000, 0, 15);
    check_all("R12 raise with hw clear");
    both(7, 2, 32'h0100_0000, 1, 14);
    bus_rd(7, 0, "R12 read cpu7");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule